// File: doc/BRIEF.md
# Chained Vector Multiply-Add Slice

This block is one execution slice of a vector unit. It evaluates D = a*X + Y over a vector held in a local register file. A single start pulse launches the whole operation. One pipelined unit multiplies each element of source register X by the scalar a. A second pipelined unit adds each product to the element of source register Y with the same index, and the sum is written to destination register D.

The product vector is never written back. Each product goes straight from the multiplier output to the adder input as soon as it exists. The add therefore waits only for the first product. After that, one result is written on every clock cycle. Integers stand in for floating point: operands are 32-bit two's complement and every result wraps to 32 bits.

The register file has 32 registers of 32 elements each. It is preloaded and inspected through a load port and a combinational read port. A run is described by a scalar, three 5-bit register indices (X, Y, D) and a 6-bit vector length.

Top module: `vmac_chain`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `wb_en_o` are all low.
- R2: For every element index i below the effective length, D[i] becomes the low 32 bits of a*X[i] added to Y[i], with wrap-around. Element i combines only with element i. Elements of D at or above the effective length keep their old value.
- R3: `wb_en_o` first rises exactly 5 clock edges after the edge that samples `start_i`, which is the multiplier latency of 3 plus the adder latency of 2. Writes then occur on consecutive cycles with no gap, and `wb_elem_o` counts 0, 1, 2 and so on.
- R4: `done_o` is high for exactly one cycle, on the cycle after the last element is written. This is the effective length plus 5 edges after the start edge. `busy_o` is high from the start edge until that edge.
- R5: A `start_i` pulse while `busy_o` is high is ignored. The running operation completes unchanged, and the register named in the ignored request is not written.
- R6: The load port (`ld_en_i`) is ignored while `busy_o` is high. The addressed element keeps its value.
- R7: A vector length of 0 is ignored: busy, done and writes all stay low. A length above 32 is treated as 32.
- R8: The result is correct when D names the same register as Y (in place) or the same register as X.
- R9: `rd_data_o` shows element `rd_elem_i` of register `rd_reg_i` in the same cycle. A load writes element `ld_elem_i` of register `ld_reg_i` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch pulse, accepted only when idle |
| scalar_i | input | 32 | Scalar multiplier a |
| xsel_i | input | 5 | Register index of X |
| ysel_i | input | 5 | Register index of Y |
| dsel_i | input | 5 | Destination register index |
| vlen_i | input | 6 | Vector length (0 ignored, above 32 clamped) |
| ld_en_i | input | 1 | Load one element into the register file |
| ld_reg_i | input | 5 | Load register index |
| ld_elem_i | input | 5 | Load element index |
| ld_data_i | input | 32 | Load data |
| rd_reg_i | input | 5 | Read register index |
| rd_elem_i | input | 5 | Read element index |
| rd_data_o | output | 32 | Read data (combinational) |
| busy_o | output | 1 | Operation in flight |
| wb_en_o | output | 1 | A result element commits at the next edge |
| wb_elem_o | output | 5 | Element index of the committing result |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a second request that lands while products and sums are still inside both pipelines. At that moment the captured configuration and the forwarded Y index must not move. The stimulus reaches it by sampling each cycle after the start edge and, two cycles in, raising `start_i` with a different destination. In a separate run it instead issues a load to an unrelated register, so both pokes arrive while elements are mid-chain. Runs with the destination aliased to X or Y exercise the read-before-write ordering between the issue point and the writeback.

// File: rtl/vmac_pkg.sv
package vmac_pkg;
    parameter int DW      = 32;  // element width
    parameter int NREG    = 32;  // vector registers (power of two)
    parameter int MAXVL   = 32;  // elements per register (power of two)
    parameter int MUL_LAT = 3;
    parameter int ADD_LAT = 2;

    localparam int RW = $clog2(NREG);
    localparam int EW = $clog2(MAXVL);
    localparam int LW = $clog2(MAXVL + 1);

    // one element travelling down a functional unit
    typedef struct packed {
        logic          v;
        logic          last;
        logic [EW-1:0] elem;
        logic [DW-1:0] data;
    } lane_t;
endpackage

// File: rtl/vmac_seq.sv
module vmac_seq
    import vmac_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] scalar_i,
    input  logic [RW-1:0] xsel_i,
    input  logic [RW-1:0] ysel_i,
    input  logic [RW-1:0] dsel_i,
    input  logic [LW-1:0] vlen_i,
    input  logic          fin_i,
    output logic          busy_o,
    output logic          iss_v_o,
    output logic          iss_last_o,
    output logic [EW-1:0] iss_elem_o,
    output logic [DW-1:0] scalar_o,
    output logic [RW-1:0] xsel_o,
    output logic [RW-1:0] ysel_o,
    output logic [RW-1:0] dsel_o
);
    typedef struct packed {
        logic          busy;
        logic          iss;
        logic [EW-1:0] idx;
        logic [EW-1:0] vlm1;
        logic [DW-1:0] scal;
        logic [RW-1:0] xs;
        logic [RW-1:0] ys;
        logic [RW-1:0] ds;
    } seq_s_t;

    seq_s_t        s_d, s_q;
    logic [LW-1:0] len_clamped;

    always_comb begin
        s_d         = s_q;
        len_clamped = (vlen_i > LW'(MAXVL)) ? LW'(MAXVL) : vlen_i;
        if (!s_q.busy && start_i && vlen_i != '0) begin
            s_d.busy = 1'b1;
            s_d.iss  = 1'b1;
            s_d.idx  = '0;
            s_d.vlm1 = EW'(len_clamped - LW'(1));
            s_d.scal = scalar_i;
            s_d.xs   = xsel_i;
            s_d.ys   = ysel_i;
            s_d.ds   = dsel_i;
        end
        if (s_q.iss) begin
            if (s_q.idx == s_q.vlm1) s_d.iss = 1'b0;
            else                     s_d.idx = s_q.idx + EW'(1);
        end
        if (fin_i) s_d.busy = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o     = s_q.busy;
    assign iss_v_o    = s_q.iss;
    assign iss_last_o = s_q.iss && (s_q.idx == s_q.vlm1);
    assign iss_elem_o = s_q.idx;
    assign scalar_o   = s_q.scal;
    assign xsel_o     = s_q.xs;
    assign ysel_o     = s_q.ys;
    assign dsel_o     = s_q.ds;

    // R5: captured configuration cannot move while an operation is in flight
    a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |=> $stable({s_q.vlm1, s_q.scal, s_q.xs, s_q.ys, s_q.ds}));
    // R7: zero length never starts an operation
    a_r7_zero_len_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && start_i && vlen_i == '0) |=> !s_q.busy);
    // R3: issue only happens inside a busy window and starts at element 0
    a_r3_issue_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.iss |-> s_q.busy);
    a_r3_first_elem_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.busy) |-> (s_q.idx == '0));
endmodule

// File: rtl/vmac_fu.sv
module vmac_fu
    import vmac_pkg::*;
#(
    parameter int LAT    = 2,
    parameter bit IS_MUL = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_v_i,
    input  logic          in_last_i,
    input  logic [EW-1:0] in_elem_i,
    input  logic [DW-1:0] opa_i,
    input  logic [DW-1:0] opb_i,
    output lane_t         out_o
);
    typedef struct packed {
        lane_t [LAT-1:0] st;
    } fu_s_t;

    fu_s_t         s_d, s_q;
    logic [DW-1:0] res;

    generate
        if (IS_MUL) begin : g_mul
            assign res = opa_i * opb_i;   // low DW bits kept
        end else begin : g_add
            assign res = opa_i + opb_i;
        end
    endgenerate

    always_comb begin
        s_d            = s_q;
        s_d.st[0].v    = in_v_i;
        s_d.st[0].last = in_last_i;
        s_d.st[0].elem = in_elem_i;
        s_d.st[0].data = res;
        for (int k = 1; k < LAT; k++) s_d.st[k] = s_q.st[k-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_o = s_q.st[LAT-1];

    // R3: once the first element leaves, the rest follow back to back, in order
    a_r3_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        (out_o.v && !out_o.last) |=> out_o.v);
    a_r3_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        (out_o.v && !out_o.last) |=> (out_o.elem == $past(out_o.elem) + EW'(1)));
endmodule

// File: rtl/vmac_vrf.sv
module vmac_vrf
    import vmac_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en_i,
    input  logic [RW-1:0] ld_reg_i,
    input  logic [EW-1:0] ld_elem_i,
    input  logic [DW-1:0] ld_data_i,
    input  logic          wb_en_i,
    input  logic [RW-1:0] wb_reg_i,
    input  logic [EW-1:0] wb_elem_i,
    input  logic [DW-1:0] wb_data_i,
    input  logic [RW-1:0] rx_reg_i,
    input  logic [EW-1:0] rx_elem_i,
    output logic [DW-1:0] rx_data_o,
    input  logic [RW-1:0] ry_reg_i,
    input  logic [EW-1:0] ry_elem_i,
    output logic [DW-1:0] ry_data_o,
    input  logic [RW-1:0] rd_reg_i,
    input  logic [EW-1:0] rd_elem_i,
    output logic [DW-1:0] rd_data_o
);
    localparam int DEPTH = NREG * MAXVL;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wb_en_i)      mem_q[{wb_reg_i, wb_elem_i}] <= wb_data_i;
        else if (ld_en_i) mem_q[{ld_reg_i, ld_elem_i}] <= ld_data_i;
    end

    assign rx_data_o = mem_q[{rx_reg_i, rx_elem_i}];
    assign ry_data_o = mem_q[{ry_reg_i, ry_elem_i}];
    assign rd_data_o = mem_q[{rd_reg_i, rd_elem_i}];

    // R6: the gated load never competes with a result write
    a_r6_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_en_i && ld_en_i));
endmodule

// File: rtl/vmac_chain.sv
module vmac_chain
    import vmac_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [DW-1:0] scalar_i,
    input  logic [RW-1:0] xsel_i,
    input  logic [RW-1:0] ysel_i,
    input  logic [RW-1:0] dsel_i,
    input  logic [LW-1:0] vlen_i,
    input  logic          ld_en_i,
    input  logic [RW-1:0] ld_reg_i,
    input  logic [EW-1:0] ld_elem_i,
    input  logic [DW-1:0] ld_data_i,
    input  logic [RW-1:0] rd_reg_i,
    input  logic [EW-1:0] rd_elem_i,
    output logic [DW-1:0] rd_data_o,
    output logic          busy_o,
    output logic          wb_en_o,
    output logic [EW-1:0] wb_elem_o,
    output logic          done_o
);
    typedef struct packed {
        logic done;
    } top_s_t;

    top_s_t        s_d, s_q;
    logic          busy, iss_v, iss_last, fin;
    logic [EW-1:0] iss_elem;
    logic [DW-1:0] scal, x_data, y_data;
    logic [RW-1:0] xs, ys, ds;
    lane_t         mul_out, add_out;

    vmac_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .scalar_i   (scalar_i),
        .xsel_i     (xsel_i),
        .ysel_i     (ysel_i),
        .dsel_i     (dsel_i),
        .vlen_i     (vlen_i),
        .fin_i      (fin),
        .busy_o     (busy),
        .iss_v_o    (iss_v),
        .iss_last_o (iss_last),
        .iss_elem_o (iss_elem),
        .scalar_o   (scal),
        .xsel_o     (xs),
        .ysel_o     (ys),
        .dsel_o     (ds)
    );

    vmac_fu #(.LAT(MUL_LAT), .IS_MUL(1'b1)) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_v_i    (iss_v),
        .in_last_i (iss_last),
        .in_elem_i (iss_elem),
        .opa_i     (x_data),
        .opb_i     (scal),
        .out_o     (mul_out)
    );

    // chaining: each product enters the adder the cycle it leaves the multiplier
    vmac_fu #(.LAT(ADD_LAT), .IS_MUL(1'b0)) u_add (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_v_i    (mul_out.v),
        .in_last_i (mul_out.last),
        .in_elem_i (mul_out.elem),
        .opa_i     (mul_out.data),
        .opb_i     (y_data),
        .out_o     (add_out)
    );

    vmac_vrf u_vrf (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_en_i   (ld_en_i && !busy),
        .ld_reg_i  (ld_reg_i),
        .ld_elem_i (ld_elem_i),
        .ld_data_i (ld_data_i),
        .wb_en_i   (add_out.v),
        .wb_reg_i  (ds),
        .wb_elem_i (add_out.elem),
        .wb_data_i (add_out.data),
        .rx_reg_i  (xs),
        .rx_elem_i (iss_elem),
        .rx_data_o (x_data),
        .ry_reg_i  (ys),
        .ry_elem_i (mul_out.elem),
        .ry_data_o (y_data),
        .rd_reg_i  (rd_reg_i),
        .rd_elem_i (rd_elem_i),
        .rd_data_o (rd_data_o)
    );

    assign fin = add_out.v && add_out.last;

    always_comb begin
        s_d      = s_q;
        s_d.done = fin;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o    = busy;
    assign wb_en_o   = add_out.v;
    assign wb_elem_o = add_out.elem;
    assign done_o    = s_q.done;

    // R4: done is a single-cycle pulse that follows the last write
    a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r4_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(wb_en_o) && !busy_o));
    // R3: results are only written during an operation
    a_r3_wb_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> busy_o);
endmodule

// File: tb/vmac_chain_tb.sv
`timescale 1ns/1ps
module vmac_chain_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] scalar_i = '0;
    logic [4:0]  xsel_i = '0, ysel_i = '0, dsel_i = '0;
    logic [5:0]  vlen_i = '0;
    logic        ld_en_i = 1'b0;
    logic [4:0]  ld_reg_i = '0, ld_elem_i = '0;
    logic [31:0] ld_data_i = '0;
    logic [4:0]  rd_reg_i = '0, rd_elem_i = '0;
    logic [31:0] rd_data_o;
    logic        busy_o, wb_en_o, done_o;
    logic [4:0]  wb_elem_o;

    logic [31:0] model [32][32];
    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    vmac_chain u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .scalar_i(scalar_i),
        .xsel_i(xsel_i), .ysel_i(ysel_i), .dsel_i(dsel_i), .vlen_i(vlen_i),
        .ld_en_i(ld_en_i), .ld_reg_i(ld_reg_i), .ld_elem_i(ld_elem_i),
        .ld_data_i(ld_data_i), .rd_reg_i(rd_reg_i), .rd_elem_i(rd_elem_i),
        .rd_data_o(rd_data_o), .busy_o(busy_o), .wb_en_o(wb_en_o),
        .wb_elem_o(wb_elem_o), .done_o(done_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(int s, int e);
        return (32'(s) * 32'h9E3779B1) ^ (32'(e) * 32'h01000193) ^ (32'(e) << 27);
    endfunction

    task automatic load_reg(int r, int seed);
        for (int e = 0; e < 32; e++) begin
            @(negedge clk);
            ld_en_i = 1'b1; ld_reg_i = 5'(r); ld_elem_i = 5'(e);
            ld_data_i = pat(seed, e);
            model[r][e] = pat(seed, e);
        end
        @(negedge clk);
        ld_en_i = 1'b0;
    endtask

    task automatic read_chk(int r, string req);
        for (int e = 0; e < 32; e++) begin
            @(negedge clk);
            rd_reg_i = 5'(r); rd_elem_i = 5'(e);
            #1;
            chk(req, rd_data_o, model[r][e]);
        end
    endtask

    // one operation; poke = 1 sends an ignored start, poke = 2 an ignored load
    task automatic run_op(logic [31:0] a, int x, int y, int d, int vl,
                          string req, int poke);
        int n = (vl > 32) ? 32 : vl;
        int first = -1, last = -1, cnt = 0, dcnt = 0, dk = -1, order_bad = 0;
        logic [31:0] nv [32];
        for (int e = 0; e < 32; e++)
            nv[e] = (e < n) ? (a * model[x][e]) + model[y][e] : model[d][e];
        @(negedge clk);
        scalar_i = a; xsel_i = 5'(x); ysel_i = 5'(y); dsel_i = 5'(d);
        vlen_i = 6'(vl); start_i = 1'b1;
        @(posedge clk);
        #1 start_i = 1'b0;
        for (int k = 1; k <= n + 12; k++) begin
            @(posedge clk);
            #1;
            if (wb_en_o) begin
                if (first < 0) first = k;
                if (wb_elem_o != 5'(cnt)) order_bad++;
                cnt++;
                last = k;
            end
            if (done_o) begin dcnt++; dk = k; end
            if (k == 1) chk("R4 busy after start", 32'(busy_o), 32'd1);
            start_i = 1'b0; ld_en_i = 1'b0;
            if (k == 2 && poke == 1) begin
                start_i = 1'b1; scalar_i = 32'd7; xsel_i = 5'd0; ysel_i = 5'd1;
                dsel_i = 5'd31; vlen_i = 6'd3;
            end
            if (k == 2 && poke == 2) begin
                ld_en_i = 1'b1; ld_reg_i = 5'd30; ld_elem_i = 5'd4;
                ld_data_i = 32'hDEAD_BEEF;
            end
        end
        chk({req, " R3 first write cycle"}, 32'(first), 32'd5);
        chk({req, " R3 last write cycle"}, 32'(last), 32'(n + 4));
        chk({req, " R3 write count"}, 32'(cnt), 32'(n));
        chk({req, " R3 element order"}, 32'(order_bad), 32'd0);
        chk({req, " R4 done count"}, 32'(dcnt), 32'd1);
        chk({req, " R4 done cycle"}, 32'(dk), 32'(n + 5));
        chk({req, " R4 idle after done"}, 32'(busy_o), 32'd0);
        for (int e = 0; e < 32; e++) model[d][e] = nv[e];
        read_chk(d, {req, " R2 result"});
        if (poke == 1) read_chk(31, "R5 ignored start target");
        if (poke == 2) read_chk(30, "R6 ignored load target");
    endtask

    task automatic test_reset();
        chk("R1 busy", 32'(busy_o), 32'd0);
        chk("R1 done", 32'(done_o), 32'd0);
        chk("R1 wb_en", 32'(wb_en_o), 32'd0);
    endtask

    task automatic test_load();
        for (int r = 0; r < 6; r++) load_reg(r, r + 11);
        load_reg(30, 77);
        load_reg(31, 91);
        read_chk(0, "R9 readback");
        read_chk(30, "R9 readback");
    endtask

    task automatic test_zero_len();
        int seen = 0;
        @(negedge clk);
        scalar_i = 32'd9; xsel_i = 5'd0; ysel_i = 5'd1; dsel_i = 5'd5;
        vlen_i = 6'd0; start_i = 1'b1;
        @(posedge clk);
        #1 start_i = 1'b0;
        for (int k = 0; k < 12; k++) begin
            @(posedge clk);
            #1;
            if (busy_o || done_o || wb_en_o) seen++;
        end
        chk("R7 zero length activity", 32'(seen), 32'd0);
        read_chk(5, "R7 zero length target");
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_load();
        run_op(32'd3, 0, 1, 2, 32, "R2 full", 0);
        run_op(-32'sd5, 3, 4, 5, 1, "R2 single", 0);
        run_op(32'd6, 0, 1, 1, 7, "R8 in-place Y", 0);
        run_op(32'h7FFF_FFFF, 3, 2, 3, 20, "R8 alias X", 0);
        run_op(32'd2, 4, 5, 2, 10, "R5 busy start", 1);
        run_op(-32'sd1, 1, 0, 4, 12, "R6 busy load", 2);
        run_op(32'h8000_0001, 2, 3, 0, 45, "R7 clamp", 0);
        test_zero_len();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule